// File: doc/BRIEF.md
# External Data Access Cycle Stretcher

This block sits between a processor core's data-memory port and the rest of the memory system. It takes each read or write request with its 16-bit address, decodes where the access goes, and times it. The access goes to a 1 KB on-chip RAM window, to the external bus, to a read-only lock-status location, or to nowhere. A 2-bit map mode selects the decoding. A 3-bit stretch setting controls how long external accesses last and how wide their strobes are.

The block counts time in machine cycles of four input clocks. Internal RAM accesses, status reads and suppressed accesses always take two machine cycles. External accesses take two machine cycles when the stretch is zero and `n+2` machine cycles for a stretch `n` of 1 to 7. For nonzero stretch, the active-low read or write strobe spans `4n` clocks, with four clocks of setup ahead of it and four of hold after it.

The block samples the address, direction, mode and stretch when it accepts a request. It keeps `busy_o` high until the access ends and marks the last clock with `done_o`. The pin drivers for the multiplexed address/data bus and the RAM array itself are outside this block.

Top module: `xms_stretch`

## Requirements
- R1: While reset is applied and on the first cycle after it, `busy_o`, `done_o` and `iram_sel_o` are 0, `rd_n_o` and `wr_n_o` are 1, and `stat_o` is 0.
- R2: In map mode 00, every address from 0000h to FFFFh is an external access: a strobe is issued and `iram_sel_o` stays low.
- R3: In map mode 01, addresses 0000h to 03FFh select internal RAM (`iram_sel_o` high for the whole access, no strobe), and addresses from 0400h upward are external.
- R4: Every internal RAM access lasts exactly 8 clocks whatever the stretch value, including stretch 7.
- R5: An external access with stretch 0 lasts 8 clocks, and its strobe is low for 2 clocks starting at clock index 3 of the access (index 0 is the first busy clock).
- R6: An external access with stretch n from 1 to 7 lasts 4(n+2) clocks, and its strobe is low for 4n clocks starting at clock index 4, which leaves 4 hold clocks.
- R7: A read drives only `rd_n_o` low and a write drives only `wr_n_o` low. The two strobes are never low together, and neither is low outside an access.
- R8: In map mode 11, addresses 0000h to 03FFh are internal. A read of FFFCh takes 8 clocks with no strobe and presents the status byte on `stat_o` during the access, with bits 2:0 equal to `lock_i` and bits 7:3 zero. Any other address from 0400h upward gives an 8-clock access with no strobe and `stat_o` at 0.
- R9: In map mode 11, a write to FFFCh changes nothing: there is no strobe, `stat_o` stays 0, and the access lasts 8 clocks.
- R10: Map mode 10 is reserved. Any access in it lasts 8 clocks with no strobe and no internal select.
- R11: The block accepts a request only while `busy_o` is low. A request, or a change of mode or stretch, while `busy_o` is high does not alter the access in progress and starts no further access.
- R12: `done_o` is high for exactly one clock, on the final clock of each access, and `busy_o` is low on the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, taken on a clock edge while not busy |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Data-memory address |
| mode_i | input | 2 | Map mode: 00 all external, 01 RAM window, 10 reserved, 11 RAM window with status location |
| stretch_i | input | 3 | Stretch value 0 to 7 |
| lock_i | input | 3 | Programmed lock bits shown in the status byte |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Final clock of the access |
| iram_sel_o | output | 1 | Internal RAM selected for this access |
| rd_n_o | output | 1 | External read strobe, active low |
| wr_n_o | output | 1 | External write strobe, active low |
| stat_o | output | 8 | Lock-status byte during a status read, otherwise 0 |

## Verification
A request is accepted on the rising edge where `req_i` is high and `busy_o` is low. Every result is then due at a fixed index counted from the first clock with `busy_o` high. The strobe falls at index 3 (stretch 0) or 4 (otherwise), `done_o` and the status byte appear at index total-1, and `busy_o` drops at index total. The bench samples on falling edges, numbers each access's busy clocks from zero, and records the strobe start, strobe width, internal-select count and the done position. When `busy_o` drops it compares these against the item its driver queued when the request was issued. Any access that has no queued item is reported, which is how requests made while busy are shown to be ignored.

// File: rtl/xms_pkg.sv
package xms_pkg;

    // Where a decoded access goes
    typedef enum logic [1:0] {
        TGT_EXT  = 2'd0,
        TGT_IRAM = 2'd1,
        TGT_STAT = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    // Map-mode encodings
    localparam logic [1:0] MAP_ALL_EXT = 2'b00;
    localparam logic [1:0] MAP_WINDOW  = 2'b01;
    localparam logic [1:0] MAP_RSVD    = 2'b10;
    localparam logic [1:0] MAP_WIN_ST  = 2'b11;

endpackage

// File: rtl/xms_decode.sv
module xms_decode
    import xms_pkg::*;
#(
    parameter int              AW         = 16,
    parameter int              IRAM_BYTES = 1024,
    parameter logic [AW-1:0]   STAT_ADDR  = 16'hFFFC
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    input  logic          we_i,
    output tgt_e          tgt_o
);
    localparam int IRAM_AW = $clog2(IRAM_BYTES);

    logic in_window;
    logic is_stat;

    always_comb begin
        in_window = (addr_i[AW-1:IRAM_AW] == '0);
        is_stat   = (addr_i == STAT_ADDR) && !we_i;
        unique case (mode_i)
            MAP_ALL_EXT: tgt_o = TGT_EXT;
            MAP_WINDOW:  tgt_o = in_window ? TGT_IRAM : TGT_EXT;
            MAP_RSVD:    tgt_o = TGT_NONE;
            default:     tgt_o = in_window ? TGT_IRAM
                                           : (is_stat ? TGT_STAT : TGT_NONE);
        endcase
    end
endmodule

// File: rtl/xms_timing.sv
module xms_timing
    import xms_pkg::*;
#(
    parameter int MC = 4,
    parameter int SW = 3,
    parameter int CW = 6
) (
    input  tgt_e           tgt_i,
    input  logic [SW-1:0]  stretch_i,
    output logic [CW-1:0]  last_o,
    output logic [CW-1:0]  s_beg_o,
    output logic [CW-1:0]  s_end_o
);
    // Fast access: two machine cycles
    localparam int FAST_LAST = 2 * MC - 1;
    // Unstretched external strobe: half a machine cycle, centred
    localparam int ZW        = MC / 2;
    localparam int ZBEG      = (2 * MC - ZW) / 2;

    logic [CW-1:0] n;

    always_comb begin
        n = CW'(stretch_i);
        if (tgt_i != TGT_EXT) begin
            last_o  = CW'(FAST_LAST);
            s_beg_o = '0;
            s_end_o = '0;
        end else if (stretch_i == '0) begin
            last_o  = CW'(FAST_LAST);
            s_beg_o = CW'(ZBEG);
            s_end_o = CW'(ZBEG + ZW);
        end else begin
            last_o  = (n + CW'(2)) * CW'(MC) - CW'(1);
            s_beg_o = CW'(MC);
            s_end_o = CW'(MC) + n * CW'(MC);
        end
    end
endmodule

// File: rtl/xms_seq.sv
module xms_seq
    import xms_pkg::*;
#(
    parameter int CW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  tgt_e          tgt_i,
    input  logic [CW-1:0] last_i,
    input  logic [CW-1:0] s_beg_i,
    input  logic [CW-1:0] s_end_i,
    input  logic [DW-1:0] stat_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          iram_sel_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [DW-1:0] stat_o
);
    typedef struct packed {
        logic          active;
        logic          we;
        tgt_e          tgt;
        logic [CW-1:0] cnt;
        logic [CW-1:0] last;
        logic [CW-1:0] s_beg;
        logic [CW-1:0] s_end;
        logic [DW-1:0] stat;
        logic          rd_n;
        logic          wr_n;
    } seq_t;

    seq_t st_d, st_q;
    logic strobe_d;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.cnt == st_q.last) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
                st_d.stat   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else if (req_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.we     = we_i;
            st_d.tgt    = tgt_i;
            st_d.last   = last_i;
            st_d.s_beg  = s_beg_i;
            st_d.s_end  = s_end_i;
            st_d.stat   = (tgt_i == TGT_STAT) ? stat_i : '0;
        end
        strobe_d  = st_d.active && (st_d.tgt == TGT_EXT) &&
                    (st_d.cnt >= st_d.s_beg) && (st_d.cnt < st_d.s_end);
        st_d.rd_n = !(strobe_d && !st_d.we);
        st_d.wr_n = !(strobe_d &&  st_d.we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.tgt    <= TGT_NONE;
            st_q.rd_n   <= 1'b1;
            st_q.wr_n   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = st_q.active;
    assign done_o     = st_q.active && (st_q.cnt == st_q.last);
    assign iram_sel_o = st_q.active && (st_q.tgt == TGT_IRAM);
    assign rd_n_o     = st_q.rd_n;
    assign wr_n_o     = st_q.wr_n;
    assign stat_o     = st_q.stat;

    // R7: strobes appear only inside an access
    a_r7_strobe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) |-> busy_o);
    // R7: read and write strobes never overlap
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));
    // R3/R4: internal RAM accesses drive no external strobe
    a_r4_iram_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        iram_sel_o |-> (rd_n_o && wr_n_o));
    // R11: an access runs until done
    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
    // R11: target of an access does not change mid-way
    a_r11_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(iram_sel_o));
    // R12: done ends the access
    a_r12_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R12: done is a single-clock pulse
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8: status byte only visible during an access
    a_r8_stat_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o != '0) |-> busy_o);
endmodule

// File: rtl/xms_stretch.sv
module xms_stretch
    import xms_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            SW         = 3,
    parameter int            MC         = 4,
    parameter int            LW         = 3,
    parameter int            DW         = 8,
    parameter int            IRAM_BYTES = 1024,
    parameter logic [AW-1:0] STAT_ADDR  = 16'hFFFC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    input  logic [SW-1:0] stretch_i,
    input  logic [LW-1:0] lock_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          iram_sel_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [DW-1:0] stat_o
);
    // Longest access: (max stretch + 2) machine cycles
    localparam int MAX_CLKS = ((1 << SW) + 1) * MC;
    localparam int CW       = $clog2(MAX_CLKS + 1);

    tgt_e          tgt;
    logic [CW-1:0] last, s_beg, s_end;
    logic [DW-1:0] stat_byte;

    assign stat_byte = DW'(lock_i);

    xms_decode #(
        .AW(AW), .IRAM_BYTES(IRAM_BYTES), .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .addr_i(addr_i),
        .mode_i(mode_i),
        .we_i  (we_i),
        .tgt_o (tgt)
    );

    xms_timing #(
        .MC(MC), .SW(SW), .CW(CW)
    ) u_timing (
        .tgt_i    (tgt),
        .stretch_i(stretch_i),
        .last_o   (last),
        .s_beg_o  (s_beg),
        .s_end_o  (s_end)
    );

    xms_seq #(
        .CW(CW), .DW(DW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .we_i      (we_i),
        .tgt_i     (tgt),
        .last_i    (last),
        .s_beg_i   (s_beg),
        .s_end_i   (s_end),
        .stat_i    (stat_byte),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .iram_sel_o(iram_sel_o),
        .rd_n_o    (rd_n_o),
        .wr_n_o    (wr_n_o),
        .stat_o    (stat_o)
    );
endmodule

// File: tb/xms_stretch_tb.sv
module xms_stretch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [1:0]  mode_i = '0;
    logic [2:0]  stretch_i = 3'd1;
    logic [2:0]  lock_i = 3'b101;
    logic        busy_o, done_o, iram_sel_o, rd_n_o, wr_n_o;
    logic [7:0]  stat_o;

    int n_total = 0;
    int n_bad   = 0;
    bit finished = 1'b0;

    typedef struct {
        int         total;
        int         s_start;
        int         s_width;
        bit         rd;
        bit         wr;
        bit         iram;
        logic [7:0] stat;
        string      tag;
    } exp_t;

    exp_t sbq[$];

    always #10 clk = ~clk;

    xms_stretch dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .mode_i(mode_i), .stretch_i(stretch_i),
        .lock_i(lock_i), .busy_o(busy_o), .done_o(done_o),
        .iram_sel_o(iram_sel_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
        .stat_o(stat_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected behaviour straight from the requirements
    function automatic exp_t model(input bit we, input logic [15:0] a,
                                   input logic [1:0] m, input int st,
                                   input string tag);
        exp_t e;
        int   kind; // 0 ext 1 iram 2 stat 3 none
        bit   win;
        win = (a < 16'h0400);
        case (m)
            2'b00:   kind = 0;
            2'b01:   kind = win ? 1 : 0;
            2'b10:   kind = 3;
            default: kind = win ? 1 : ((a == 16'hFFFC && !we) ? 2 : 3);
        endcase
        e.tag = tag; e.total = 8; e.s_start = 0; e.s_width = 0;
        e.rd = 0; e.wr = 0; e.iram = (kind == 1);
        e.stat = (kind == 2) ? {5'b0, lock_i} : 8'h00;
        if (kind == 0) begin
            e.rd = !we; e.wr = we;
            if (st == 0) begin e.total = 8; e.s_start = 3; e.s_width = 2; end
            else begin e.total = 4 * (st + 2); e.s_start = 4; e.s_width = 4 * st; end
        end
        return e;
    endfunction

    task automatic issue(input bit we, input logic [15:0] a, input logic [1:0] m,
                         input int st, input string tag);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        we_i = we; addr_i = a; mode_i = m; stretch_i = 3'(st);
        req_i = 1'b1;
        sbq.push_back(model(we, a, m, st, tag));
        @(negedge clk);
        req_i = 1'b0;
    endtask

    // Monitor: measures each access and compares against the queue
    initial begin : mon
        int idx, first, lows, iram_c, done_c, done_at;
        bit rdl, wrl, in_acc;
        logic [7:0] st;
        exp_t e;
        in_acc = 0; idx = 0; first = -1; lows = 0; iram_c = 0;
        done_c = 0; done_at = -1; rdl = 0; wrl = 0; st = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (busy_o) begin
                if (!in_acc) begin
                    in_acc = 1; idx = 0; first = -1; lows = 0; iram_c = 0;
                    done_c = 0; done_at = -1; rdl = 0; wrl = 0; st = '0;
                end
                if (!rd_n_o || !wr_n_o) begin
                    if (first < 0) first = idx;
                    lows++;
                end
                if (!rd_n_o) rdl = 1;
                if (!wr_n_o) wrl = 1;
                if (iram_sel_o) iram_c++;
                if (done_o) begin done_c++; done_at = idx; st = stat_o; end
                idx++;
            end else if (in_acc) begin
                in_acc = 0;
                if (sbq.size() == 0) begin
                    check(0, "R11", "unexpected access", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    check(idx == e.total, e.tag, "access length", idx, e.total);
                    check(done_c == 1 && done_at == e.total - 1, {e.tag, " R12"},
                          "done position", done_at, e.total - 1);
                    check(lows == e.s_width, {e.tag, " R7"}, "strobe width",
                          lows, e.s_width);
                    if (e.s_width > 0)
                        check(first == e.s_start, e.tag, "strobe start",
                              first, e.s_start);
                    check(rdl == e.rd && wrl == e.wr, {e.tag, " R7"},
                          "strobe kind rd/wr", int'({rdl, wrl}), int'({e.rd, e.wr}));
                    check(iram_c == (e.iram ? e.total : 0), e.tag, "iram select clocks",
                          iram_c, e.iram ? e.total : 0);
                    check(st == e.stat, e.tag, "status byte", int'(st), int'(e.stat));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!busy_o && !done_o && !iram_sel_o && rd_n_o && wr_n_o && stat_o == 0,
              "R1", "outputs in reset", int'({busy_o, done_o, iram_sel_o, rd_n_o, wr_n_o}), 5'b00011);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !iram_sel_o && rd_n_o && wr_n_o && stat_o == 0,
              "R1", "outputs after reset", int'({busy_o, done_o, iram_sel_o, rd_n_o, wr_n_o}), 5'b00011);

        // R2 / R5 / R6: mode 00
        issue(0, 16'h0010, 2'b00, 1, "R2 R6 rd lo st1");
        issue(1, 16'h8000, 2'b00, 0, "R2 R5 wr st0");
        issue(0, 16'hFFFF, 2'b00, 0, "R2 R5 rd top st0");
        for (int s = 1; s < 8; s++) issue(0, 16'h1234, 2'b00, s, "R6 rd sweep");
        issue(1, 16'h0400, 2'b00, 7, "R6 wr st7");

        // R3 / R4: mode 01
        issue(0, 16'h03FF, 2'b01, 5, "R3 R4 rd win top");
        issue(1, 16'h0000, 2'b01, 7, "R3 R4 wr win st7");
        issue(1, 16'h0400, 2'b01, 2, "R3 wr above win");

        // R8 / R9 / R4: mode 11
        issue(0, 16'hFFFC, 2'b11, 3, "R8 status read");
        lock_i = 3'b010;
        issue(0, 16'hFFFC, 2'b11, 0, "R8 status read 2");
        issue(0, 16'hFFFD, 2'b11, 4, "R8 other upper");
        issue(0, 16'h0400, 2'b11, 1, "R8 above win");
        issue(0, 16'h0100, 2'b11, 7, "R4 win mode11");
        issue(1, 16'hFFFC, 2'b11, 6, "R9 status write");

        // R10: reserved mode
        issue(0, 16'h0000, 2'b10, 3, "R10 rd");
        issue(1, 16'h9000, 2'b10, 7, "R10 wr");

        // R11: request and setting changes while busy are ignored
        issue(0, 16'h2000, 2'b00, 2, "R11 held access");
        repeat (3) @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = 16'h0001; mode_i = 2'b01; stretch_i = 3'd7;
        @(negedge clk);
        req_i = 1'b0;
        repeat (6) @(negedge clk);
        mode_i = 2'b00; stretch_i = 3'd0;

        // R12 back-to-back: next access after done
        issue(0, 16'h4000, 2'b00, 0, "R12 follow-up");

        @(negedge clk);
        while (busy_o || sbq.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        check(!busy_o, "R11", "idle after last access", int'(busy_o), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule